// File: doc/BRIEF.md
# Stop-Mode Power Controller

This block puts a small microcontroller into its deepest low-power state and brings it back. Software writes a three-bit control word. Bit 0 asks for stop mode. Bit 1 picks what the external pins do while stopped. Bit 2 switches the subclock off. Once stopped, the main clock is gated off. Register and RAM contents are kept because nothing is reset. The pins are either frozen at their last value or released to high impedance, and pads with a pull-up configured are then pulled up.

The block wakes on a reset or on an external interrupt whose enable is set. A watch-timer interrupt also wakes it, but only while the subclock is left running. After an interrupt wake, the main clock stays gated for a fixed oscillation-stabilization wait. This wait is counted on the raw oscillator clock. When the wait ends, the CPU gets a one-cycle resume pulse and the peripherals carry on where they stopped. A reset skips the wait and the resume pulse. A two-bit cause field records what ended the last stop.

Top module: `stop_ctrl`

## Requirements
- R1: A write with `wr_data[0]=1` while running sets `stop_active` after that clock edge, and `main_clk_en` goes low at the next falling edge. A write with `wr_data[0]=0` only updates the configuration.
- R2: While `stop_active` is high, `pin_hold` is high if the latched `wr_data[1]` was 0, and `pin_hiz` is high if it was 1. Both are low while running.
- R3: `sub_clk_en` equals the inverse of the latched `wr_data[2]`. A watch interrupt cannot wake the block while the subclock is stopped.
- R4: An external interrupt wakes the block from stop only if `ext_ie` is high. Otherwise it is ignored.
- R5: A watch interrupt with `watch_ie` high wakes the block while the subclock runs.
- R6: After an interrupt wake, `stop_active` stays high and `main_clk_en` stays low for exactly STAB_CYC more rising edges. The pin policy holds during this wait.
- R7: `cpu_resume` pulses high for exactly one cycle when an interrupt-started wait ends. It never pulses for a reset.
- R8: Reset is asynchronous. It forces run state, clock enabled, configuration cleared, and `wake_cause`=3.
- R9: `wake_cause` is 1 for an external wake and 2 for a watch wake. External wins when both arrive in the same cycle.
- R10: `main_clk_en` changes only on the falling edge of `clk_osc`, and it is always the inverse of `stop_active` at rising edges.
- R11: Register writes while stopped or waiting have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Raw oscillator clock, always running |
| rst_n | input | 1 | Asynchronous active-low reset, also a wake source |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 3 | [0] stop request, [1] pins high-Z, [2] subclock off |
| ext_irq | input | 1 | External interrupt request |
| ext_ie | input | 1 | External interrupt enable |
| watch_irq | input | 1 | Watch prescaler/counter interrupt |
| watch_ie | input | 1 | Watch interrupt enable |
| main_clk_en | output | 1 | Main clock gate enable |
| stop_active | output | 1 | Stop bit; high from entry until the wait ends |
| pin_hold | output | 1 | Pins keep their last state |
| pin_hiz | output | 1 | Pins high impedance (pull-ups honoured) |
| sub_clk_en | output | 1 | Subclock oscillator enable |
| cpu_resume | output | 1 | One-cycle pulse when the main clock is back |
| wake_cause | output | 2 | 1 external, 2 watch, 3 reset |

## Verification
The bench targets a masked external interrupt and a watch interrupt arriving while the subclock is off. A design that got either wrong would leave stop early and restart the clock. It checks the edge where the stabilization count ends: an off-by-one design releases the clock one cycle early or late. It sends external and watch interrupts in the same cycle, where a wrong priority reports cause 2. It applies a reset in mid-stop, where a design that takes the interrupt path would pulse `cpu_resume` or report the wrong cause. It also writes the control word while stopped, which must leave the pin policy and subclock unchanged.

// File: rtl/stop_ctrl.sv
module stop_ctrl #(
  parameter int STAB_CYC = 16
) (
  input  logic       clk_osc,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_data,
  input  logic       ext_irq,
  input  logic       ext_ie,
  input  logic       watch_irq,
  input  logic       watch_ie,
  output logic       main_clk_en,
  output logic       stop_active,
  output logic       pin_hold,
  output logic       pin_hiz,
  output logic       sub_clk_en,
  output logic       cpu_resume,
  output logic [1:0] wake_cause
);
  localparam int CW = $clog2(STAB_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(STAB_CYC - 1);

  typedef enum logic [1:0] {S_RUN, S_STOP, S_WAIT} st_t;

  st_t           st;
  logic          pinsel, substop, clk_en_q;
  logic [CW-1:0] cnt;

  wire ext_hit   = ext_irq & ext_ie;
  wire watch_hit = watch_irq & watch_ie & ~substop;

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_RUN;
      pinsel     <= 1'b0;
      substop    <= 1'b0;
      cnt        <= '0;
      wake_cause <= 2'd3;
      cpu_resume <= 1'b0;
    end else begin
      cpu_resume <= 1'b0;
      case (st)
        S_RUN: if (wr_en) begin
          pinsel  <= wr_data[1];
          substop <= wr_data[2];
          if (wr_data[0]) st <= S_STOP;
        end
        S_STOP: if (ext_hit || watch_hit) begin
          st         <= S_WAIT;
          cnt        <= '0;
          wake_cause <= ext_hit ? 2'd1 : 2'd2;
        end
        S_WAIT: if (cnt == LAST) begin
          st         <= S_RUN;
          cpu_resume <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: st <= S_RUN;
      endcase
    end
  end

  always_ff @(negedge clk_osc or negedge rst_n) begin
    if (!rst_n) clk_en_q <= 1'b1;
    else        clk_en_q <= (st == S_RUN);
  end

  assign main_clk_en = clk_en_q;
  assign stop_active = (st != S_RUN);
  assign pin_hold    = stop_active & ~pinsel;
  assign pin_hiz     = stop_active & pinsel;
  assign sub_clk_en  = ~substop;

  p_pins_exclusive_r2: assert property (@(posedge clk_osc) disable iff (!rst_n)
    !(pin_hold && pin_hiz));

  p_gate_matches_stop_r10: assert property (@(posedge clk_osc) disable iff (!rst_n)
    main_clk_en == !stop_active);

  p_single_pulse_r7: assert property (@(posedge clk_osc) disable iff (!rst_n)
    cpu_resume |=> !cpu_resume);

  p_watch_blocked_r3: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (st == S_STOP && !ext_hit && watch_irq && watch_ie && substop) |=> (st == S_STOP));

  p_masked_ext_r4: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (st == S_STOP && ext_irq && !ext_ie && !watch_hit) |=> (st == S_STOP));

  p_write_ignored_r11: assert property (@(posedge clk_osc) disable iff (!rst_n)
    (st != S_RUN && wr_en) |=> ($stable(pinsel) && $stable(substop)));
endmodule

// File: tb/stop_ctrl_test.sv
module stop_ctrl_test;
  localparam int STAB = 16;

  logic clk = 0, rst_n = 0, wr_en = 0, ext_irq = 0, ext_ie = 0, watch_irq = 0, watch_ie = 0;
  logic [2:0] wr_data = '0;
  logic main_clk_en, stop_active, pin_hold, pin_hiz, sub_clk_en, cpu_resume;
  logic [1:0] wake_cause;

  always #4 clk = ~clk;

  stop_ctrl #(.STAB_CYC(STAB)) uut (
    .clk_osc(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ext_irq(ext_irq), .ext_ie(ext_ie), .watch_irq(watch_irq), .watch_ie(watch_ie),
    .main_clk_en(main_clk_en), .stop_active(stop_active), .pin_hold(pin_hold),
    .pin_hiz(pin_hiz), .sub_clk_en(sub_clk_en), .cpu_resume(cpu_resume),
    .wake_cause(wake_cause));

  int vectors = 0, bad = 0;

  // behavioural reference: mode 0 run, 1 stopped, 2 waiting
  int m_mode, m_rem, m_cause;
  bit m_hiz, m_suboff, m_res, m_clk;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_mode = 0; m_rem = 0; m_cause = 3; m_hiz = 0; m_suboff = 0; m_res = 0;
    end else begin
      m_res = 0;
      if (m_mode == 0) begin
        if (wr_en) begin
          m_hiz = wr_data[1]; m_suboff = wr_data[2];
          if (wr_data[0]) m_mode = 1;
        end
      end else if (m_mode == 1) begin
        if (ext_irq && ext_ie) begin m_mode = 2; m_rem = STAB; m_cause = 1; end
        else if (watch_irq && watch_ie && !m_suboff) begin m_mode = 2; m_rem = STAB; m_cause = 2; end
      end else begin
        m_rem--;
        if (m_rem == 0) begin m_mode = 0; m_res = 1; end
      end
    end
  end

  always @(negedge clk or negedge rst_n)
    if (!rst_n) m_clk = 1; else m_clk = (m_mode == 0);

  task automatic chk(string tag, int got, int exp);
    vectors++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #7;
    chk("R1 stop_active", stop_active, m_mode != 0);
    chk("R10 main_clk_en", main_clk_en, m_clk);
    chk("R2 pin_hold", pin_hold, (m_mode != 0) && !m_hiz);
    chk("R2 pin_hiz", pin_hiz, (m_mode != 0) && m_hiz);
    chk("R3 sub_clk_en", sub_clk_en, !m_suboff);
    chk("R7 cpu_resume", cpu_resume, m_res);
    chk("R9 wake_cause", wake_cause, m_cause);
  end

  task automatic nxt(int n = 1);
    repeat (n) begin @(posedge clk); #6; end
  endtask

  task automatic wr(logic [2:0] d);
    wr_en = 1; wr_data = d; nxt(); wr_en = 0;
  endtask

  bit done = 0;

  initial begin
    nxt(2);
    chk("R8 reset cause", wake_cause, 3);
    chk("R8 reset clk", main_clk_en, 1);
    rst_n = 1;
    nxt();
    // hold pins, masked external interrupt then enabled one
    wr(3'b001);
    chk("R1 entered", stop_active, 1);
    chk("R1 clock gated", main_clk_en, 0);
    chk("R2 hold", pin_hold, 1);
    ext_irq = 1; nxt(3);
    chk("R4 masked ext ignored", stop_active, 1);
    ext_ie = 1; nxt(); ext_irq = 0;
    nxt(STAB - 1);
    chk("R6 still waiting", stop_active, 1);
    chk("R6 clock still gated", main_clk_en, 0);
    chk("R6 pins held in wait", pin_hold, 1);
    nxt();
    chk("R6 clock back", main_clk_en, 1);
    chk("R7 resume pulse", cpu_resume, 1);
    chk("R9 ext cause", wake_cause, 1);
    nxt();
    chk("R7 pulse ended", cpu_resume, 0);
    // high-Z pins, watch wake with subclock running
    wr(3'b011);
    chk("R2 hiz", pin_hiz, 1);
    chk("R3 subclock on", sub_clk_en, 1);
    watch_irq = 1; watch_ie = 1; nxt(); watch_irq = 0;
    nxt(STAB);
    chk("R5 watch wake", stop_active, 0);
    chk("R9 watch cause", wake_cause, 2);
    // subclock off: watch blocked, write ignored, ext wakes
    wr(3'b101);
    chk("R3 subclock off", sub_clk_en, 0);
    watch_irq = 1; nxt(3);
    chk("R3 watch blocked", stop_active, 1);
    wr(3'b010);
    chk("R11 pins unchanged", pin_hold, 1);
    chk("R11 subclock unchanged", sub_clk_en, 0);
    ext_irq = 1; nxt(); ext_irq = 0; watch_irq = 0;
    nxt(STAB);
    chk("R4 ext wake", stop_active, 0);
    // simultaneous sources
    wr(3'b001);
    ext_irq = 1; watch_irq = 1; nxt(); ext_irq = 0; watch_irq = 0;
    nxt(STAB);
    chk("R9 priority ext", wake_cause, 1);
    // config-only write, then reset in mid-stop
    wr(3'b010);
    chk("R1 config only", stop_active, 0);
    chk("R2 run pins", pin_hiz, 0);
    wr(3'b001);
    nxt(2);
    rst_n = 0; #1;
    chk("R8 async run", stop_active, 0);
    chk("R8 async cause", wake_cause, 3);
    chk("R8 async clk", main_clk_en, 1);
    nxt(); rst_n = 1; nxt();
    chk("R7 no resume on reset", cpu_resume, 0);
    chk("R8 config cleared", sub_clk_en, 1);
    nxt(3);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: got hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, bad);
      $finish;
    end
  end
endmodule